// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM that never needs an idle cycle when the bus changes direction. Every enabled rising clock edge accepts one command: either a fresh operation on an external address or a continuation of the current burst. The data bus follows the command two enabled edges later, so reads and writes may be issued back to back in any mix. The array is made of words split into byte lanes, and each lane can be written separately.

A single advance/load input picks between loading a new address and continuing the burst. A continuation repeats the previous operation type on the next address in a four-word wrapping group. A clock-enable stall or a sleep request freezes the whole pipeline. The tri-state data bus is modelled as separate input, output and output-enable signals. Output enable acts combinationally and is masked whenever the output stage does not hold a read.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is deselected and `dq_oe_o` stays low, whatever `oe_n_i` is, until a read reaches the output stage.
- R2: On an enabled edge with `adv_i` low, the command is taken from the pins: `ce_n_i` high gives a deselect, otherwise `we_n_i` high gives a read and `we_n_i` low gives a write, all on `addr_i`.
- R3: Data for a read loaded at enabled edge N is on `dq_o` with `dq_oe_o` high after enabled edge N+2. Write data for a write loaded at enabled edge N is taken from `dq_i` at enabled edge N+2.
- R4: On an enabled edge with `adv_i` high, the previous operation type (deselect, read or write) is repeated, and `ce_n_i`, `we_n_i` and `addr_i` have no effect.
- R5: A continuation adds one, modulo four, to address bits [1:0] and keeps the upper address bits of the burst.
- R6: `bw_n_i[k]` low, sampled on the same edge as the write's address, updates lane k, which is bits 9k+8 down to 9k. Any mix of lanes is legal. With all four high, the write is aborted and no word changes.
- R7: While the output stage holds a write or a deselect, `dq_oe_o` is low even when `oe_n_i` is low.
- R8: `oe_n_i` is not registered: `dq_oe_o` follows it within the same cycle while a read is in the output stage. A read with `oe_n_i` high is a dummy read that still advances the burst.
- R9: With `cen_n_i` high, the edge is ignored: the address, the burst and every pipeline stage hold, no word is written and `dq_oe_o` is low.
- R10: With `sleep_i` high, every other input is ignored, no operation takes place, the pipeline holds and `dq_oe_o` is low.
- R11: A read loaded on the edge right after a write to the same word returns the new lanes merged with the old ones, not the stale word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep request, active high |
| cen_n_i | input | 1 | Clock enable, active low |
| ce_n_i | input | 1 | Chip enable, active low, used on load cycles |
| adv_i | input | 1 | High: continue the burst; low: load a new command |
| we_n_i | input | 1 | Write enable, active low, used on load cycles |
| bw_n_i | input | LANES | Byte-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low, combinational |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The bench builds the block with its defaults: 64 words, a two-bit burst field and four 9-bit lanes. At this depth every word can be filled with a burst and read back. A four-word group is short enough that wrap-around shows up in every burst that starts past the group's first word. A reference model that is fed the same pins predicts `dq_oe_o` and the read data on every clock. The run covers alternating reads and writes to one word, partial and aborted byte writes, and stalls and sleep in the middle of bursts.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

   // Operation carried down the pipeline
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

endpackage

// File: rtl/zbt_sram_ctrl.sv
// Command decode, burst address counter and the two-stage command pipe.
module zbt_sram_ctrl
   import zbt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              adv_i,
   input  logic              ce_n_i,
   input  logic              we_n_i,
   input  logic [LANES-1:0]  bw_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   output op_e               ld_op,
   output logic [ADDR_W-1:0] ld_addr,
   output op_e               pl_op,
   output logic [ADDR_W-1:0] pl_addr,
   output logic [LANES-1:0]  pl_bw
);

   localparam int HI_W = ADDR_W - BURST_W;

   op_e               new_op;
   logic [ADDR_W-1:0] burst_next;
   logic [LANES-1:0]  ld_bw;

   always_comb begin
      if (ce_n_i)      new_op = OP_IDLE;
      else if (we_n_i) new_op = OP_RD;
      else             new_op = OP_WR;
   end

   // Linear wrap inside the aligned group; upper bits are held
   logic [HI_W-1:0]    grp_bits;
   logic [BURST_W-1:0] off_bits;
   assign grp_bits   = ld_addr[ADDR_W-1:BURST_W];
   assign off_bits   = ld_addr[BURST_W-1:0] + BURST_W'(1);
   assign burst_next = {grp_bits, off_bits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_op   <= OP_IDLE;
         ld_addr <= '0;
         ld_bw   <= '0;
         pl_op   <= OP_IDLE;
         pl_addr <= '0;
         pl_bw   <= '0;
      end else if (en) begin
         pl_op   <= ld_op;
         pl_addr <= ld_addr;
         pl_bw   <= ld_bw;
         ld_bw   <= ~bw_n_i;
         if (!adv_i) begin
            ld_op   <= new_op;
            ld_addr <= addr_i;
         end else begin
            ld_addr <= burst_next;
         end
      end
   end

endmodule

// File: rtl/zbt_sram_array.sv
// Lane-split storage with a registered read port and a same-edge write bypass.
module zbt_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [LANES-1:0]        wr_strb,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic [LANES*LANE_W-1:0] rd_q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic same_word;
   assign same_word = (wr_addr == rd_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] wr_lane;
      logic [LANE_W-1:0] rd_lane;

      assign wr_lane = wr_data[l*LANE_W +: LANE_W];

      always_ff @(posedge clk) begin
         if (wr_strb[l]) store[wr_addr] <= wr_lane;
         if (en) rd_lane <= (wr_strb[l] && same_word) ? wr_lane : store[rd_addr];
      end

      assign rd_q[l*LANE_W +: LANE_W] = rd_lane;
   end

endmodule

// File: rtl/zbt_sram_outstage.sv
// Output register and the combinational drive enable.
module zbt_sram_outstage #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              pl_rd,
   input  logic [DATA_W-1:0] rd_q,
   input  logic              oe_n_i,
   output logic              out_rd,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_rd <= 1'b0;
         dq_o   <= '0;
      end else if (en) begin
         out_rd <= pl_rd;
         dq_o   <= rd_q;
      end
   end

   assign dq_oe_o = out_rd & ~oe_n_i & en;

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep_i,
   input  logic                    cen_n_i,
   input  logic                    ce_n_i,
   input  logic                    adv_i,
   input  logic                    we_n_i,
   input  logic [LANES-1:0]        bw_n_i,
   input  logic                    oe_n_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe_o
);

   localparam int DATA_W = LANES * LANE_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   logic              en;
   op_e               ld_op;
   op_e               pl_op;
   logic [ADDR_W-1:0] ld_addr;
   logic [ADDR_W-1:0] pl_addr;
   logic [LANES-1:0]  pl_bw;
   logic [LANES-1:0]  wr_strb;
   logic [DATA_W-1:0] rd_q;
   logic              out_rd;

   assign en      = ~cen_n_i & ~sleep_i;
   assign wr_strb = (en && pl_op == OP_WR) ? pl_bw : '0;

   zbt_sram_ctrl #(
      .ADDR_W (ADDR_W),
      .BURST_W(BURST_W),
      .LANES  (LANES)
   ) ctrl_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .adv_i  (adv_i),
      .ce_n_i (ce_n_i),
      .we_n_i (we_n_i),
      .bw_n_i (bw_n_i),
      .addr_i (addr_i),
      .ld_op  (ld_op),
      .ld_addr(ld_addr),
      .pl_op  (pl_op),
      .pl_addr(pl_addr),
      .pl_bw  (pl_bw)
   );

   zbt_sram_array #(
      .ADDR_W(ADDR_W),
      .LANES (LANES),
      .LANE_W(LANE_W)
   ) array_i (
      .clk    (clk),
      .en     (en),
      .rd_addr(ld_addr),
      .wr_strb(wr_strb),
      .wr_addr(pl_addr),
      .wr_data(dq_i),
      .rd_q   (rd_q)
   );

   zbt_sram_outstage #(
      .DATA_W(DATA_W)
   ) out_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .pl_rd  (pl_op == OP_RD),
      .rd_q   (rd_q),
      .oe_n_i (oe_n_i),
      .out_rd (out_rd),
      .dq_o   (dq_o),
      .dq_oe_o(dq_oe_o)
   );

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
   import zbt_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              sleep_i,
   input logic              adv_i,
   input logic [ADDR_W-1:0] addr_i,
   input op_e               ld_op,
   input logic [ADDR_W-1:0] ld_addr,
   input op_e               pl_op,
   input logic              out_rd,
   input logic              dq_oe_o
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!out_rd && ld_op == OP_IDLE && pl_op == OP_IDLE));

   // R2
   load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv_i) |=> (ld_addr == $past(addr_i)));

   // R3
   read_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pl_op == OP_RD) |=> out_rd);

   // R4
   burst_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_i) |=> (ld_op == $past(ld_op)));

   // R5
   burst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv_i) |=>
         ((ld_addr[ADDR_W-1:BURST_W] == $past(ld_addr[ADDR_W-1:BURST_W])) &&
          (ld_addr[BURST_W-1:0] == BURST_W'($past(ld_addr[BURST_W-1:0]) + 1'b1))));

   // R7
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pl_op == OP_WR) |=> !dq_oe_o);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(ld_op) && $stable(ld_addr) && $stable(pl_op) && $stable(out_rd)));

   // R10
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> ($stable(ld_op) && $stable(ld_addr) && $stable(out_rd)));

endmodule

bind zbt_sram zbt_sram_chk #(
   .ADDR_W (ADDR_W),
   .BURST_W(BURST_W)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .sleep_i(sleep_i),
   .adv_i  (adv_i),
   .addr_i (addr_i),
   .ld_op  (ld_op),
   .ld_addr(ld_addr),
   .pl_op  (pl_op),
   .out_rd (out_rd),
   .dq_oe_o(dq_oe_o)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sleep;
   logic        cen_n;
   logic        ce_n;
   logic        adv;
   logic        we_n;
   logic [3:0]  bw_n;
   logic        oe_n;
   logic [5:0]  addr;
   logic [35:0] dq_i;
   logic [35:0] dq_o;
   logic        dq_oe_o;

   always #5 clk = ~clk;

   zbt_sram dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .cen_n_i(cen_n), .ce_n_i(ce_n),
      .adv_i(adv), .we_n_i(we_n), .bw_n_i(bw_n), .oe_n_i(oe_n), .addr_i(addr),
      .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
   );

   int    checks = 0;
   int    fails  = 0;
   int    cycles = 0;
   bit    done   = 0;
   string tag    = "R1";
   bit    oe_cur = 0;

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model (op: 0 idle, 1 read, 2 write) ----------------
   int          m_op [2];
   logic [5:0]  m_ad [2];
   logic [3:0]  m_bw [2];
   int          last_op;
   logic [5:0]  last_ad;
   int          o_n;
   logic [5:0]  a_n;
   logic [35:0] mem [64];
   bit   [3:0]  kn  [64];
   bit          exp_rd;
   bit          exp_oe;
   logic [35:0] exp_dat;
   logic [35:0] exp_msk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_op[0] = 0; m_op[1] = 0; exp_rd = 0; last_op = 0; last_ad = '0;
      end else if (!cen_n && !sleep) begin
         if (m_op[0] == 2)
            for (int l = 0; l < 4; l++)
               if (m_bw[0][l]) begin
                  mem[m_ad[0]][l*9 +: 9] = dq_i[l*9 +: 9];
                  kn[m_ad[0]][l] = 1'b1;
               end
         exp_rd = (m_op[0] == 1);
         if (exp_rd) begin
            exp_dat = mem[m_ad[0]];
            for (int l = 0; l < 4; l++) exp_msk[l*9 +: 9] = {9{kn[m_ad[0]][l]}};
         end
         m_op[0] = m_op[1]; m_ad[0] = m_ad[1]; m_bw[0] = m_bw[1];
         if (!adv) begin
            o_n = ce_n ? 0 : (we_n ? 1 : 2);
            a_n = addr;
         end else begin
            o_n = last_op;
            a_n = {last_ad[5:2], last_ad[1:0] + 2'd1};
         end
         m_op[1] = o_n; m_ad[1] = a_n; m_bw[1] = ~bw_n;
         last_op = o_n; last_ad = a_n;
      end
      #2;
      if (!done) begin
         exp_oe = rst_n && exp_rd && !oe_n && !cen_n && !sleep;
         chk(dq_oe_o === exp_oe, tag, 36'(dq_oe_o), 36'(exp_oe));
         if (exp_oe && dq_oe_o)
            chk(((dq_o ^ exp_dat) & exp_msk) == '0, tag, dq_o & exp_msk, exp_dat & exp_msk);
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL R3 watchdog act=%0d exp<=%0d", cycles, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drv(input bit c, input bit s, input bit ad, input bit ce, input bit we,
                      input logic [3:0] bw, input bit oe, input logic [5:0] a);
      @(negedge clk);
      cen_n = c; sleep = s; adv = ad; ce_n = ce; we_n = we;
      bw_n = bw; oe_n = oe; addr = a;
      dq_i = {4'($urandom()), $urandom()};
   endtask

   task automatic ld_rd(input logic [5:0] a);
      drv(0, 0, 0, 0, 1, 4'($urandom()), oe_cur, a);
   endtask

   task automatic ld_wr(input logic [5:0] a, input logic [3:0] bw);
      drv(0, 0, 0, 0, 0, bw, oe_cur, a);
   endtask

   // Continuation with the ignored pins scrambled (R4)
   task automatic cont(input logic [3:0] bw);
      drv(0, 0, 1, 1'($urandom()), 1'($urandom()), bw, oe_cur, 6'($urandom()));
   endtask

   task automatic desel();
      drv(0, 0, 0, 1, 1'($urandom()), 4'($urandom()), oe_cur, 6'($urandom()));
   endtask

   task automatic stall();
      drv(1, 0, 1'($urandom()), 1'($urandom()), 1'($urandom()), 4'($urandom()), oe_cur, 6'($urandom()));
   endtask

   task automatic nap();
      drv(1'($urandom()), 1, 1'($urandom()), 0, 0, 4'h0, 0, 6'($urandom()));
   endtask

   // ---------------- test sequence ----------------
   initial begin
      rst_n = 0; sleep = 0; cen_n = 0; ce_n = 1; adv = 0; we_n = 1;
      bw_n = 4'hF; oe_n = 0; addr = '0; dq_i = '0;

      // R1: reset with output enable active
      tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1;
      oe_cur = 0;
      repeat (3) desel();

      // R2: fill the array with full-lane write bursts
      tag = "R2";
      for (int g = 0; g < 16; g++) begin
         ld_wr(6'(g*4), 4'h0);
         repeat (3) cont(4'h0);
      end
      repeat (2) desel();

      // R3: single reads back to back
      tag = "R3";
      for (int i = 0; i < 24; i++) ld_rd(6'($urandom()));
      repeat (3) desel();

      // R5: bursts that start mid-group and wrap
      tag = "R5";
      for (int i = 0; i < 6; i++) begin
         ld_rd(6'(i*9 + 2));
         repeat (5) cont(4'hF);
      end
      ld_wr(6'd31, 4'h0);
      repeat (4) cont(4'h0);
      ld_rd(6'd29);
      repeat (5) cont(4'hF);
      repeat (3) desel();

      // R4: continuations with chip/write enables and address scrambled
      tag = "R4";
      ld_rd(6'd16);
      repeat (7) cont(4'hF);
      ld_wr(6'd40, 4'h5);
      repeat (7) cont(4'($urandom()));
      ld_rd(6'd40);
      repeat (3) cont(4'hF);
      desel();
      repeat (4) cont(4'hF);
      repeat (3) desel();

      // R6: partial and aborted byte writes, then read back
      tag = "R6";
      for (int i = 0; i < 16; i++) ld_wr(6'(i), 4'($urandom()));
      ld_wr(6'd50, 4'hF);
      ld_wr(6'd51, 4'hF);
      repeat (2) desel();
      for (int i = 0; i < 16; i++) ld_rd(6'(i));
      ld_rd(6'd50);
      ld_rd(6'd51);
      repeat (3) desel();

      // R7: alternate write and read every cycle with output enable held active
      tag = "R7";
      for (int i = 0; i < 20; i++) begin
         ld_wr(6'($urandom()), 4'($urandom()));
         ld_rd(6'($urandom()));
      end
      repeat (3) desel();

      // R8: dummy reads and combinational output enable
      tag = "R8";
      oe_cur = 1;
      ld_rd(6'd8);
      repeat (3) cont(4'hF);
      @(negedge clk);
      #1 chk(dq_oe_o === 1'b0, "R8", 36'(dq_oe_o), 36'd0);
      oe_n = 0;
      #1 chk(dq_oe_o === 1'b1, "R8", 36'(dq_oe_o), 36'd1);
      chk(((dq_o ^ exp_dat) & exp_msk) == '0, "R8", dq_o & exp_msk, exp_dat & exp_msk);
      oe_n = 1;
      #1 chk(dq_oe_o === 1'b0, "R8", 36'(dq_oe_o), 36'd0);
      oe_cur = 0;
      repeat (2) cont(4'hF);
      oe_cur = 1;
      ld_rd(6'd12);
      cont(4'hF);
      oe_cur = 0;
      repeat (2) cont(4'hF);
      repeat (3) desel();

      // R9: stalls inside bursts
      tag = "R9";
      ld_rd(6'd20);
      stall();
      cont(4'hF);
      repeat (3) stall();
      repeat (2) cont(4'hF);
      ld_wr(6'd22, 4'h0);
      stall();
      stall();
      cont(4'h0);
      ld_rd(6'd22);
      stall();
      repeat (3) cont(4'hF);
      repeat (3) desel();

      // R10: sleep with writes attempted on every pin
      tag = "R10";
      ld_rd(6'd33);
      repeat (5) nap();
      repeat (3) cont(4'hF);
      repeat (6) nap();
      ld_rd(6'd0);
      repeat (3) cont(4'hF);
      repeat (3) desel();

      // R11: read right behind a write to the same word
      tag = "R11";
      for (int i = 0; i < 20; i++) begin
         logic [5:0] a;
         a = 6'($urandom());
         ld_wr(a, 4'($urandom()));
         ld_rd(a);
         ld_wr(a, 4'($urandom()));
         ld_rd(a);
         ld_rd(a);
      end
      repeat (3) desel();

      // R2: mixed random traffic
      tag = "R2";
      for (int i = 0; i < 3000; i++) begin
         drv(($urandom() % 10) == 0, ($urandom() % 25) == 0, ($urandom() % 3) == 0,
             ($urandom() % 8) == 0, 1'($urandom()), 4'($urandom()),
             ($urandom() % 5) == 0, 6'($urandom()));
      end
      repeat (4) desel();

      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule